// File: doc/BRIEF.md
# Modem Status Register

This block holds the modem status byte of a 16550-style serial port. It watches four active-low modem lines from the pins: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The upper nibble of the byte shows the synchronized lines inverted, so a 1 means the line is asserted. The lower nibble holds four sticky change flags, and reading the byte clears them.

In loopback mode the upper nibble no longer follows the pins. It takes four modem control bits from the control register instead. Change detection then works on those looped-back values, so software can exercise the flags without external wiring. An interrupt request goes high while any flag is set, if the modem-status interrupt enable is high. Interrupt priority and the rest of the UART are handled elsewhere.

Top module: `modem_status_reg`

## Requirements
- R1: During and after reset, `rd_data[3:0]` reads 0 and `irq` is 0. With all pins held high, `rd_data[7:4]` reads 0.
- R2: Outside loopback, `rd_data[4]`, `[5]`, `[6]` and `[7]` are the inverted `cts_n_i`, `dsr_n_i`, `ri_n_i` and `dcd_n_i`. A pin change is not visible after one rising clock edge. It is visible after the second edge.
- R3: Flag bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set when their line changes level, in either direction.
- R4: Flag bit 2 sets only when `ri_n_i` goes from 0 to 1. A 1-to-0 change of `ri_n_i` leaves bit 2 at 0.
- R5: A cycle with `rd_stb` high clears flag bits 0 to 3 at the next clock edge. `rd_data` during that cycle still shows the flags as they were before the clear.
- R6: A change detected in the same cycle as a read is not returned by that read. Its flag is 1 after the read.
- R7: With `loopback` high, `rd_data[4]`, `[5]`, `[6]` and `[7]` equal `mcr_rts`, `mcr_dtr`, `mcr_out1` and `mcr_out2`. Pin changes then alter neither the status bits nor the flags.
- R8: In loopback, toggling a control bit sets the matching flag. A 1-to-0 change of `mcr_out1` sets bit 2, and a 0-to-1 change of `mcr_out1` does not.
- R9: `irq` is high exactly when `msi_en` is high and at least one flag is set. With `msi_en` low, `irq` stays 0 while the flags still read back as set.
- R10: Flags are sticky. Once set, a flag stays 1 until a read, and flags from separate events accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| loopback | input | 1 | Loopback enable from the modem control register |
| mcr_rts | input | 1 | Request-to-send control bit |
| mcr_dtr | input | 1 | Data-terminal-ready control bit |
| mcr_out1 | input | 1 | User output 1 control bit |
| mcr_out2 | input | 1 | User output 2 control bit |
| msi_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Read strobe for the status byte; clears the flags |
| rd_data | output | 8 | Status byte: flags in [3:0], line state in [7:4] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The pins are swept through all 256 ordered pairs of 4-bit patterns. Before each pair the flags are cleared by a read. This shows that every line is detected in both directions, that the ring flag reacts to only one edge, and that no line leaks into another line's flag. The same 256-pair sweep is repeated on the control bits in loopback. During that sweep the pins are inverted before every check, to show they are ignored. Directed sequences place a line change in the same cycle as a read, gate the interrupt with the enable, measure the two-edge synchronizer latency, and accumulate flags from separate events.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       loopback,
  input  logic       mcr_rts,
  input  logic       mcr_dtr,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       msi_en,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int NL = 4;
  localparam int RI = 2;

  logic [NL-1:0] pins_n;
  logic [NL-1:0] sync_q [SYNC_STAGES];
  logic [NL-1:0] live, prev_q, delta, flags_q;

  assign pins_n = {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= pins_n;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign live = loopback ? {mcr_out2, mcr_out1, mcr_dtr, mcr_rts}
                         : ~sync_q[SYNC_STAGES-1];

  always_comb begin
    delta     = prev_q ^ live;
    delta[RI] = prev_q[RI] & ~live[RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= live;
      flags_q <= (rd_stb ? '0 : flags_q) | delta;
    end
  end

  assign rd_data = {live, flags_q};
  assign irq     = msi_en & (|flags_q);
endmodule

module modem_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loopback,
  input logic       mcr_rts,
  input logic       mcr_dtr,
  input logic       mcr_out1,
  input logic       mcr_out2,
  input logic       msi_en,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       irq
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_stb && $stable(rd_data[7:4])) |=> (rd_data[3:0] == 4'h0));

  a_r3_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rd_stb && !$stable(rd_data[4])) |=> rd_data[0]);

  a_r4_ri_assert_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rd_stb && $rose(rd_data[6]) && !rd_data[2]) |=> !rd_data[2]);

  a_r7_loop_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && loopback && $past(loopback) &&
     $stable({mcr_out2, mcr_out1, mcr_dtr, mcr_rts})) |-> $stable(rd_data[7:4]));
endmodule

bind modem_status_reg modem_status_reg_chk chk (
  .clk(clk), .rst_n(rst_n), .loopback(loopback), .mcr_rts(mcr_rts),
  .mcr_dtr(mcr_dtr), .mcr_out1(mcr_out1), .mcr_out2(mcr_out2),
  .msi_en(msi_en), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
  logic loopback = 1'b0;
  logic mcr_rts = 1'b0, mcr_dtr = 1'b0, mcr_out1 = 1'b0, mcr_out2 = 1'b0;
  logic msi_en = 1'b1;
  logic rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  modem_status_reg dut (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i),
    .ri_n_i(ri_n_i), .dcd_n_i(dcd_n_i), .loopback(loopback),
    .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr), .mcr_out1(mcr_out1),
    .mcr_out2(mcr_out2), .msi_en(msi_en), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i} = p;
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} = c;
  endtask

  // read: strobe for one cycle, return data seen during the strobe
  task automatic do_read(output logic [7:0] d);
    rd_stb = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] la, input logic [3:0] lb);
    logic [3:0] f;
    f = la ^ lb;
    f[2] = la[2] & ~lb[2];
    return f;
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(1);
    #1;
    check("R1 flags in reset", {4'h0, rd_data[3:0]}, 8'h00);
    check("R1 irq in reset", {7'h0, irq}, 8'h00);
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
    #1;
    check("R1 after reset", rd_data, 8'h00);
    check("R1 irq after reset", {7'h0, irq}, 8'h00);

    // R2 synchronizer latency
    set_pins(4'b1110);
    @(posedge clk); #1;
    check("R2 one edge", {4'h0, rd_data[7:4]}, 8'h00);
    @(posedge clk); #1;
    check("R2 two edges", {4'h0, rd_data[7:4]}, 8'h01);
    cyc(3);
    do_read(d);
    check("R3 cts fall flag", {4'h0, d[3:0]}, 8'h01);

    // exhaustive pin transitions: R2 R3 R4 R5 R9
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] ef;
        set_pins(a[3:0]);
        cyc(4);
        do_read(d);
        cyc(1); #1;
        check("R5 cleared after read", {4'h0, rd_data[3:0]}, 8'h00);
        set_pins(b[3:0]);
        cyc(4); #1;
        ef = exp_flags(~a[3:0], ~b[3:0]);
        check("R2 status", {4'h0, rd_data[7:4]}, {4'h0, ~b[3:0]});
        check("R3 R4 flags", {4'h0, rd_data[3:0]}, {4'h0, ef});
        check("R9 irq", {7'h0, irq}, {7'h0, |ef});
      end
    end
    do_read(d);

    // R6: change lands in the read cycle
    set_pins(4'b1111);
    cyc(4);
    do_read(d);
    set_pins(4'b0111);
    cyc(2);
    do_read(d);
    check("R6 read returns old", {4'h0, d[3:0]}, 8'h00);
    #1;
    check("R6 flag kept", {4'h0, rd_data[3:0]}, 8'h08);
    do_read(d);
    check("R5 returns flags", {4'h0, d[3:0]}, 8'h08);
    cyc(1); #1;
    check("R5 then clear", {4'h0, rd_data[3:0]}, 8'h00);

    // R9: enable low
    msi_en = 1'b0;
    set_pins(4'b0101);
    cyc(4); #1;
    check("R9 irq masked", {7'h0, irq}, 8'h00);
    check("R9 flag visible", {4'h0, rd_data[3:0]}, 8'h02);
    msi_en = 1'b1;
    #1;
    check("R9 irq enabled", {7'h0, irq}, 8'h01);

    // R10: accumulate separate events
    set_pins(4'b0100);
    cyc(10);
    set_pins(4'b1100);
    cyc(10); #1;
    check("R10 accumulate", {4'h0, rd_data[3:0]}, 8'h0B);
    do_read(d);

    // loopback sweep: R7 R8
    set_ctrl(4'h0);
    loopback = 1'b1;
    cyc(2);
    do_read(d);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] ef;
        set_ctrl(a[3:0]);
        cyc(2);
        do_read(d);
        set_ctrl(b[3:0]);
        cyc(1);
        set_pins(~{dcd_n_i, ri_n_i, dsr_n_i, cts_n_i});
        cyc(4); #1;
        ef = exp_flags(a[3:0], b[3:0]);
        check("R7 loop status", {4'h0, rd_data[7:4]}, {4'h0, b[3:0]});
        check("R8 loop flags", {4'h0, rd_data[3:0]}, {4'h0, ef});
      end
    end
    loopback = 1'b0;
    cyc(4);
    do_read(d);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule